// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial line as asynchronous frames. A holding register takes the next byte from the bus or from a DMA controller while the previous byte is still being shifted out, so a steady stream leaves the pin with no idle bits between frames. Bit timing comes from a one-cycle baud tick supplied from outside. The block does not generate its own baud rate.

Software runs a handshake through the status register. It reads the status and sees the empty flag at 1. It then writes a byte into the data register and writes 0 to the empty flag, which releases the byte for sending. A transfer-request line is raised while the holding register is empty and transmit is enabled. A DMA controller can answer that request with a write strobe, and the DMA write clears the empty flag by itself. A second flag reports that every queued byte, including the one in the shift register, has fully left the pin.

When transmit is disabled, the pin is given to a simple port made of a direction bit and a data bit. This is how a break is sent. Software sets direction to output and data to 0, then disables transmit, and the line stays low until software changes the port.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset the status reads empty=1 and end=1, transmit is disabled, `pin_oe` is 0 and `txe_irq` is 0.
- R2: The register map is as follows. Address 0 is the data byte. Address 1 is the control register, where bit 0 enables transmit. Address 2 is the status register, where bit 0 is the empty flag and bit 1 is the end flag. Address 3 is the port register, where bit 0 is direction and bit 1 is data.
- R3: A status write with bit 0 equal to 0 clears the empty flag only if the status was read with empty=1 after the last status write. Without that read, the write has no effect and nothing is sent.
- R4: Each frame is one low start bit, then 8 data bits LSB first, then one high stop bit. Each bit lasts from one baud tick to the next. A released byte starts on the first tick after its release while the shift register is idle.
- R5: When a byte moves into the shift register, the empty flag returns to 1 and the end flag goes to 0. The end flag stays 0 while a frame is on the line.
- R6: The end flag is set at the close of a stop bit only if no byte is waiting. A byte released before that moment follows with no idle bit in between.
- R7: `txe_irq` is high exactly when the empty flag is 1 and transmit is enabled. A `dma_wr` strobe loads `dma_data` into the data register and clears the empty flag with no software clear.
- R8: With transmit enabled and no frame in progress, `pin_oe` is 1 and `pin_out` is 1.
- R9: With transmit disabled, `pin_oe` equals the port direction bit, and when it is 1 `pin_out` equals the port data bit. Direction=1 with data=0 holds a continuous low, which is a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational from the address |
| dma_wr | input | 1 | DMA write of the data register |
| dma_data | input | 8 | DMA write data |
| txe_irq | output | 1 | Data-register-empty request |
| pin_out | output | 1 | Serial pin value |
| pin_oe | output | 1 | Serial pin output enable |

## Verification
The hardest case to reach is a release that arrives while the stop bit of the previous frame is still on the line. Only this case shows whether the second frame follows with no gap and whether the end flag stays low through the handover. The bench drives the baud tick slowly enough that its polling software, and separately a DMA responder reacting to the request line, always release the next byte inside the current frame. It then measures the number of idle bits between decoded frames. A status clear without the prior read is also set up on purpose: the bench first writes the status to drop the read arming, then watches that the pin stays idle.

// File: rtl/sertx_pkg.sv
// Shared constants for the double-buffered serial transmitter.
// Assumes a byte-wide bus; field positions below are decoded by the bench.
package sertx_pkg;
    parameter int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_CTRL = 2'd1,
        A_STAT = 2'd2,
        A_PORT = 2'd3
    } addr_e;

    localparam int unsigned ST_EMPTY = 0;
    localparam int unsigned ST_END   = 1;
    localparam int unsigned CT_EN    = 0;
    localparam int unsigned PT_DIR   = 0;
    localparam int unsigned PT_DAT   = 1;
endpackage

// File: rtl/sertx_regs.sv
// Register file and flag logic: holding register, enable, port bits,
// empty/end flags with the read-then-clear handshake and DMA auto-clear.
// Assumes load and done pulses come from the shift engine, one cycle wide.
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          dma_wr,
    input  logic [DW-1:0] dma_data,
    input  logic          load,
    input  logic          done,
    output logic [DW-1:0] hold_q,
    output logic          tx_en,
    output logic          empty,
    output logic          end_flag,
    output logic          armed,
    output logic          port_dir,
    output logic          port_dat,
    output logic          txe_irq
);
    logic wr_data, wr_ctrl, wr_stat, wr_port, rd_stat;

    // Decode bus strobes per register.
    always_comb begin
        wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);
        wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
        wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
        wr_port = bus_sel && bus_wr && (bus_addr == A_PORT);
        rd_stat = bus_sel && bus_rd && (bus_addr == A_STAT);
    end

    // Holding register, control and port bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            tx_en    <= 1'b0;
            port_dir <= 1'b0;
            port_dat <= 1'b0;
        end else begin
            if (wr_data) hold_q <= bus_wdata;
            if (dma_wr)  hold_q <= dma_data;
            if (wr_ctrl) tx_en  <= bus_wdata[CT_EN];
            if (wr_port) begin
                port_dir <= bus_wdata[PT_DIR];
                port_dat <= bus_wdata[PT_DAT];
            end
        end
    end

    // Read arming: a status read that saw empty=1 permits one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wr_stat || dma_wr) begin
            armed <= 1'b0;
        end else if (rd_stat && empty) begin
            armed <= 1'b1;
        end
    end

    // Empty flag: set on transfer to the shifter, cleared by handshake or DMA.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty <= 1'b1;
        end else begin
            if (load) empty <= 1'b1;
            if (wr_stat && !bus_wdata[ST_EMPTY] && armed) empty <= 1'b0;
            if (dma_wr) empty <= 1'b0;
        end
    end

    // End flag: cleared when a frame starts, set when the line drains.
    always_ff @(posedge clk) begin
        if (!rst_n)    end_flag <= 1'b1;
        else if (load) end_flag <= 1'b0;
        else if (done) end_flag <= 1'b1;
    end

    // Read mux and request line.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA: bus_rdata = hold_q;
            A_CTRL: bus_rdata[CT_EN] = tx_en;
            A_STAT: begin
                bus_rdata[ST_EMPTY] = empty;
                bus_rdata[ST_END]   = end_flag;
            end
            default: begin
                bus_rdata[PT_DIR] = port_dir;
                bus_rdata[PT_DAT] = port_dat;
            end
        endcase
        txe_irq = empty && tx_en;
    end
endmodule

// File: rtl/sertx_shift.sv
// Frame shift engine: start bit, DW data bits LSB first, stop bit.
// Assumes baud_tick is a single-cycle pulse; reloads in the stop-bit tick
// so back-to-back frames have no idle bit. Disabling aborts the frame.
module sertx_shift #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          pending,
    input  logic [DW-1:0] hold_q,
    output logic          load,
    output logic          done,
    output logic          busy,
    output logic          line
);
    localparam int unsigned FRAME = DW + 2;
    localparam int unsigned CW    = $clog2(FRAME);

    logic [FRAME-1:0] sh_q;
    logic [CW-1:0]    cnt_q;
    logic             last;

    // Transfer and completion decisions for this tick.
    always_comb begin
        last = (cnt_q == CW'(FRAME - 1));
        load = tick && en && pending && (!busy || last);
        done = tick && busy && last && !load;
        line = busy ? sh_q[0] : 1'b1;
    end

    // Shift register, bit counter and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh_q  <= '1;
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            sh_q  <= {1'b1, hold_q, 1'b0};
            cnt_q <= '0;
            busy  <= 1'b1;
        end else if (tick && busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                sh_q  <= {1'b1, sh_q[FRAME-1:1]};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sertx_pinmux.sv
// Pin ownership: serial engine when enabled, general-purpose port otherwise.
// Assumes the pad driver treats pin_out as don't-care when pin_oe is 0.
module sertx_pinmux (
    input  logic tx_en,
    input  logic line,
    input  logic port_dir,
    input  logic port_dat,
    output logic pin_out,
    output logic pin_oe
);
    // Select the pin source.
    always_comb begin
        if (tx_en) begin
            pin_oe  = 1'b1;
            pin_out = line;
        end else begin
            pin_oe  = port_dir;
            pin_out = port_dat;
        end
    end
endmodule

// File: rtl/sertx_dbuf.sv
// Top of the double-buffered asynchronous transmitter: registers, shift
// engine and pin mux. Assumes an external baud tick and a byte-wide bus.
module sertx_dbuf
    import sertx_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          dma_wr,
    input  logic [DW-1:0] dma_data,
    output logic          txe_irq,
    output logic          pin_out,
    output logic          pin_oe
);
    logic [DW-1:0] hold_q;
    logic tx_en, empty, end_flag, armed, port_dir, port_dat;
    logic load, done, busy, line;

    sertx_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_wr(dma_wr), .dma_data(dma_data),
        .load(load), .done(done),
        .hold_q(hold_q), .tx_en(tx_en), .empty(empty), .end_flag(end_flag),
        .armed(armed), .port_dir(port_dir), .port_dat(port_dat),
        .txe_irq(txe_irq)
    );

    sertx_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_en),
        .pending(!empty), .hold_q(hold_q),
        .load(load), .done(done), .busy(busy), .line(line)
    );

    sertx_pinmux u_pin (
        .tx_en(tx_en), .line(line), .port_dir(port_dir), .port_dat(port_dat),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/sertx_dbuf_chk.sv
// Checker for sertx_dbuf: flag handshakes, frame state and pin ownership.
module sertx_dbuf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       clr_bit,
    input logic       dma_wr,
    input logic       load,
    input logic       busy,
    input logic       empty,
    input logic       end_flag,
    input logic       armed,
    input logic       tx_en,
    input logic       port_dir,
    input logic       port_dat,
    input logic       pin_out,
    input logic       pin_oe
);
    logic clr_try;
    always_comb clr_try = bus_sel && bus_wr && (bus_addr == 2'd2) && !clr_bit;

    p_load_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load && !dma_wr |=> empty);
    p_end_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !end_flag);
    p_unarmed_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_try && !armed && !dma_wr && !load |=> $stable(empty));
    p_dma_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |=> !empty);
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && !busy |-> pin_oe && pin_out);
    p_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (pin_oe == port_dir) && (!port_dir || pin_out == port_dat));
endmodule

bind sertx_dbuf sertx_dbuf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .clr_bit(bus_wdata[0]), .dma_wr(dma_wr),
    .load(load), .busy(busy), .empty(empty), .end_flag(end_flag),
    .armed(armed), .tx_en(tx_en), .port_dir(port_dir), .port_dat(port_dat),
    .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sertx_dbuf_test.sv
// Bench for sertx_dbuf: directed corners plus seeded random byte streams,
// decoded from the pin and compared with bench-side expectations.
module sertx_dbuf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       dma_wr = 1'b0;
    logic [7:0] dma_data = 8'd0;
    logic       txe_irq, pin_out, pin_oe;

    int n_tests = 0;
    int n_fail  = 0;

    sertx_dbuf uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_wr(dma_wr), .dma_data(dma_data), .txe_irq(txe_irq),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #10 clk = ~clk;

    // Pin decoder state.
    logic       mon_on = 1'b0;
    int         rx_pos = -1;
    int         rx_n = 0;
    int         idle_bits = 99;
    int         stop_err = 0;
    logic [7:0] rx_sh;
    logic [7:0] rx_buf [0:63];
    int         gap_buf [0:63];

    // Expected values.
    logic [7:0] exp_buf [0:63];
    logic [7:0] dma_list [0:15];
    int         dma_idx = 0;
    int         dma_len = 0;
    logic       dma_on = 1'b0;

    function automatic logic [7:0] exp_stat(input logic emp, input logic endf);
        return {6'd0, endf, emp};
    endfunction

    function automatic logic [1:0] exp_pin(input logic en, input logic dir, input logic dat);
        if (en) return 2'b11;
        return {dir, dir ? dat : 1'b0};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample_bit();
        if (!mon_on) return;
        if (rx_pos < 0) begin
            if (pin_oe && !pin_out) begin
                rx_pos = 0;
                gap_buf[rx_n] = idle_bits;
            end else begin
                idle_bits++;
            end
        end else if (rx_pos < 8) begin
            rx_sh[rx_pos] = pin_out;
            rx_pos++;
        end else begin
            if (pin_out !== 1'b1) stop_err++;
            rx_buf[rx_n] = rx_sh;
            rx_n++;
            rx_pos = -1;
            idle_bits = 0;
        end
    endtask

    // Baud tick every 4 clocks; the pin is sampled once per bit.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            sample_bit();
        end
    end

    // DMA responder: answers the request line with one write per byte.
    initial begin
        forever begin
            @(negedge clk);
            if (dma_on && txe_irq && dma_idx < dma_len) begin
                dma_wr = 1'b1;
                dma_data = dma_list[dma_idx];
                dma_idx++;
                @(negedge clk);
                dma_wr = 1'b0;
            end
        end
    end

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic send_sw(input logic [7:0] b, output logic [7:0] s);
        int t = 0;
        brd(2'd2, s);
        while (!s[0] && t < 500) begin
            brd(2'd2, s);
            t++;
        end
        bwr(2'd0, b);
        bwr(2'd2, 8'h00);
    endtask

    task automatic wait_end();
        logic [7:0] s;
        int t = 0;
        brd(2'd2, s);
        while (!s[1] && t < 2000) begin
            brd(2'd2, s);
            t++;
        end
    endtask

    task automatic wait_rx(input int n);
        int t = 0;
        while (rx_n < n && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Main sequence.
    initial begin
        logic [7:0] s;
        logic [1:0] p;
        int base;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        brd(2'd2, s);
        chk("R1 status", s, exp_stat(1'b1, 1'b1));
        brd(2'd1, s);
        chk("R1 ctrl", s, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", txe_irq, 0);

        // R9: port owns the pin while disabled.
        bwr(2'd3, 8'h02);
        p = exp_pin(1'b0, 1'b0, 1'b1);
        chk("R9 dir0 oe", pin_oe, p[1]);
        bwr(2'd3, 8'h03);
        p = exp_pin(1'b0, 1'b1, 1'b1);
        chk("R9 dir1 dat1", {pin_oe, pin_out}, p);
        bwr(2'd3, 8'h01);
        p = exp_pin(1'b0, 1'b1, 1'b0);
        chk("R9 dir1 dat0", {pin_oe, pin_out}, p);
        brd(2'd3, s);
        chk("R2 port readback", s, 8'h01);
        bwr(2'd3, 8'h00);

        // R8 and R7: enable, idle high, request raised.
        bwr(2'd1, 8'h01);
        p = exp_pin(1'b1, 1'b0, 1'b0);
        chk("R8 idle", {pin_oe, pin_out}, p);
        chk("R7 irq enabled", txe_irq, 1);
        mon_on = 1'b1;

        // R3: clear without a prior read is ignored.
        bwr(2'd2, 8'h03);
        bwr(2'd0, 8'hA5);
        bwr(2'd2, 8'h00);
        repeat (60) @(negedge clk);
        chk("R3 no frame", rx_n, 0);
        chk("R3 pin idle", pin_out, 1);
        brd(2'd2, s);
        chk("R3 still empty", s, exp_stat(1'b1, 1'b1));

        // R4 and R5: read-armed clear sends one frame.
        bwr(2'd0, 8'h3C);
        bwr(2'd2, 8'h00);
        repeat (12) @(negedge clk);
        brd(2'd2, s);
        chk("R5 during frame", s, exp_stat(1'b1, 1'b0));
        wait_rx(1);
        chk("R4 byte", rx_buf[0], 8'h3C);
        wait_end();
        brd(2'd2, s);
        chk("R6 end after frame", s, exp_stat(1'b1, 1'b1));

        // R6: software back-to-back burst, no idle bits.
        base = rx_n;
        for (int i = 0; i < 4; i++) begin
            exp_buf[i] = 8'($urandom);
            send_sw(exp_buf[i], s);
            if (i > 0) chk("R6 end low in burst", s[1], 0);
        end
        wait_rx(base + 4);
        wait_end();
        for (int i = 0; i < 4; i++) begin
            chk("R4 burst byte", rx_buf[base + i], exp_buf[i]);
            if (i > 0) chk("R6 no gap", gap_buf[base + i], 0);
        end
        chk("R4 stop bits", stop_err, 0);

        // R7: DMA-served stream.
        base = rx_n;
        dma_len = 6;
        for (int i = 0; i < 6; i++) dma_list[i] = 8'($urandom);
        dma_list[0] = 8'hFF;
        dma_list[1] = 8'h00;
        dma_on = 1'b1;
        wait_rx(base + 6);
        dma_on = 1'b0;
        wait_end();
        for (int i = 0; i < 6; i++) begin
            chk("R7 dma byte", rx_buf[base + i], dma_list[i]);
            if (i > 0) chk("R7 dma no gap", gap_buf[base + i], 0);
        end
        brd(2'd2, s);
        chk("R7 dma drained", s, exp_stat(1'b1, 1'b1));
        chk("R4 stop bits dma", stop_err, 0);

        // R9: break after the end of transmission.
        mon_on = 1'b0;
        bwr(2'd3, 8'h01);
        bwr(2'd1, 8'h00);
        chk("R7 irq disabled", txe_irq, 0);
        for (int i = 0; i < 5; i++) begin
            repeat (7) @(negedge clk);
            p = exp_pin(1'b0, 1'b1, 1'b0);
            chk("R9 break low", {pin_oe, pin_out}, p);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule